// File: doc/BRIEF.md
# Bus Test Target with Checksum

This block is a small target on an 8-bit parallel bus whose only job is to let a host prove that single and burst accesses reach it intact. Every read returns a pattern the host can predict from the address alone, and every written byte is folded into an 8-bit checksum register. One burst write of eight distinct one-hot bytes, followed by one burst read, exercises every byte lane in both directions.

The host selects the block with a chip select and issues strobes. With the burst input low each strobe is a self-contained single access at the presented address. With the burst input high, consecutive strobes inside one chip-select assertion form a burst of up to eight beats; the block counts beats and steps the effective address itself, so the host only presents the start address on the first beat. Offset zero reads back the checksum; any other offset reads back its own low three address bits.

Top module: `bt_target`

## Requirements
- R1: While rst_n is low the checksum is 0x00, the beat counter is 0 and rd_data is 0x00.
- R2: An accepted read whose effective address is nonzero sets rd_data to {5'b00000, effective address bits [2:0]} at the clock edge that samples the strobe, so it is visible in the following cycle.
- R3: An accepted read whose effective address is 0x00 sets rd_data to the checksum value held before that edge.
- R4: An accepted write with burst low replaces the checksum with wr_data.
- R5: In a burst, the first accepted write beat replaces the checksum with its data and each later write beat adds its data modulo 256; the checksum changes on no other event.
- R6: Beat n of a burst (n counted from 0) uses effective address (start address + n) modulo 256, where the start address is the addr value on beat 0; addr is ignored on later beats.
- R7: A burst holds at most 8 beats; once 8 beats are taken, every further strobe, burst or not, is ignored until cs has been low for at least one clock edge.
- R8: A clock edge with cs low ends any burst (the next burst strobe starts at beat 0), and strobes with cs low are ignored.
- R9: rd_data holds its value on every edge without an accepted read; when rd_stb and wr_stb are high together, the write is taken and the read is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| cs | input | 1 | Chip select, active high |
| addr | input | 8 | Access address (start address for bursts) |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Read strobe, one beat per sampled high cycle |
| wr_stb | input | 1 | Write strobe, one beat per sampled high cycle |
| burst | input | 1 | High: strobe belongs to a burst of up to 8 beats |
| rd_data | output | 8 | Registered read data |

## Verification
A read result is due exactly one clock after the edge that samples its strobe, and a write changes the checksum at that same edge, so the bench drives each beat on a falling edge, drops the strobe on the next falling edge and samples rd_data there, half a period after the register updated. Write effects are never observed directly; they are read back through offset zero in a later access, after which the bench model's checksum must match. The address pattern is swept over all 256 addresses, burst reads are swept over sixteen start addresses including the wrap past 0xFF, and burst write lengths from one to eight beats are checked against an arithmetic sum.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned MAX_BEATS = 8;
  localparam int unsigned PAT_W     = 3;
  localparam int unsigned CNT_W     = $clog2(MAX_BEATS + 1);

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/bt_beat_ctrl.sv
module bt_beat_ctrl
  import bt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs,
  input  logic  rd_stb,
  input  logic  wr_stb,
  input  logic  burst,
  input  addr_t addr,
  output logic  wr_acc,
  output logic  rd_acc,
  output logic  first_beat,
  output addr_t eff_addr,
  output cnt_t  beat_cnt
);
  localparam cnt_t CNT_FULL = cnt_t'(MAX_BEATS);

  cnt_t  cnt_q, cnt_d;
  addr_t base_q, base_d;
  logic  cnt_en, base_en;
  logic  full, take;

  always_comb begin
    full       = (cnt_q == CNT_FULL);
    take       = cs && (rd_stb || wr_stb) && !full;
    wr_acc     = take && wr_stb;
    rd_acc     = take && rd_stb && !wr_stb;
    first_beat = !burst || (cnt_q == '0);
    if (first_beat) begin
      eff_addr = addr;
    end else begin
      eff_addr = base_q + addr_t'(cnt_q);
    end
  end

  always_comb begin
    cnt_en  = 1'b0;
    cnt_d   = cnt_q;
    base_en = 1'b0;
    base_d  = base_q;
    if (!cs) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (take) begin
      cnt_en = 1'b1;
      if (burst) begin
        cnt_d = cnt_q + cnt_t'(1);
        if (cnt_q == '0) begin
          base_en = 1'b1;
          base_d  = addr;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  assign beat_cnt = cnt_q;
endmodule

// File: rtl/bt_sum_reg.sv
module bt_sum_reg
  import bt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_acc,
  input  logic  first_beat,
  input  data_t wr_data,
  output data_t sum
);
  data_t sum_q, sum_d;
  logic  sum_en;

  always_comb begin
    sum_en = wr_acc;
    if (first_beat) begin
      sum_d = wr_data;
    end else begin
      sum_d = sum_q + wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (sum_en) begin
      sum_q <= sum_d;
    end
  end

  assign sum = sum_q;
endmodule

// File: rtl/bt_read_mux.sv
module bt_read_mux
  import bt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_acc,
  input  addr_t eff_addr,
  input  data_t sum,
  output data_t rd_data
);
  data_t rd_q, rd_d;
  logic  rd_en;

  always_comb begin
    rd_en = rd_acc;
    if (eff_addr == '0) begin
      rd_d = sum;
    end else begin
      rd_d = data_t'(eff_addr[PAT_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/bt_target.sv
module bt_target
  import bt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic [7:0] addr,
  input  logic [7:0] wr_data,
  input  logic       rd_stb,
  input  logic       wr_stb,
  input  logic       burst,
  output logic [7:0] rd_data
);
  logic  wr_acc, rd_acc, first_beat;
  addr_t eff_addr;
  cnt_t  beat_cnt;
  data_t sum_q;

  bt_beat_ctrl u_beat (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs         (cs),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .burst      (burst),
    .addr       (addr),
    .wr_acc     (wr_acc),
    .rd_acc     (rd_acc),
    .first_beat (first_beat),
    .eff_addr   (eff_addr),
    .beat_cnt   (beat_cnt)
  );

  bt_sum_reg u_sum (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_acc     (wr_acc),
    .first_beat (first_beat),
    .wr_data    (wr_data),
    .sum        (sum_q)
  );

  bt_read_mux u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_acc   (rd_acc),
    .eff_addr (eff_addr),
    .sum      (sum_q),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/bt_target_chk.sv
module bt_target_chk
  import bt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic [7:0] addr,
  input logic [7:0] wr_data,
  input logic       rd_stb,
  input logic       wr_stb,
  input logic       burst,
  input logic [7:0] rd_data,
  input data_t      sum_q,
  input cnt_t       beat_cnt
);
  localparam cnt_t CNT_FULL = cnt_t'(MAX_BEATS);

  // R7: the beat counter never passes the burst limit
  p_beat_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_cnt <= CNT_FULL);

  // R8: a cycle with cs low returns the counter to beat 0
  p_cs_low_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> beat_cnt == '0);

  // R9: no accepted read leaves rd_data unchanged
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs || !rd_stb || wr_stb) |=> $stable(rd_data));

  // R5: checksum changes only on a write strobe under cs
  p_sum_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && wr_stb) |=> $stable(sum_q));

  // R4: single write loads the checksum
  p_single_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr_stb && !burst && beat_cnt != CNT_FULL) |=> sum_q == $past(wr_data));

  // R2: single read of a nonzero address returns its low bits
  p_pattern_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd_stb && !wr_stb && !burst && beat_cnt != CNT_FULL && addr != 8'h00)
      |=> rd_data == {5'b00000, $past(addr[2:0])});
endmodule

bind bt_target bt_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs       (cs),
  .addr     (addr),
  .wr_data  (wr_data),
  .rd_stb   (rd_stb),
  .wr_stb   (wr_stb),
  .burst    (burst),
  .rd_data  (rd_data),
  .sum_q    (sum_q),
  .beat_cnt (beat_cnt)
);

// File: tb/bt_target_bench.sv
module bt_target_bench;
  logic       clk;
  logic       rst_n;
  logic       cs;
  logic [7:0] addr;
  logic [7:0] wr_data;
  logic       rd_stb;
  logic       wr_stb;
  logic       burst;
  logic [7:0] rd_data;

  int checks   = 0;
  int failures = 0;
  logic [7:0] m_sum;
  logic done = 1'b0;

  bt_target u_bt_target (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .burst   (burst),
    .rd_data (rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] ea, input logic [7:0] s);
    return (ea == 8'h00) ? s : {5'b00000, ea[2:0]};
  endfunction

  // one strobe; on return rd_data holds the result of this beat
  task automatic beat(input logic w, input logic r, input logic c,
                      input logic [7:0] a, input logic [7:0] d, input logic b);
    @(negedge clk);
    cs = c; addr = a; wr_data = d; burst = b; wr_stb = w; rd_stb = r;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic cs_gap();
    @(negedge clk);
    cs = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic read_sum(input string tag);
    cs_gap();
    beat(1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0);
    chk(tag, rd_data, m_sum);
  endtask

  initial begin
    rst_n = 1'b0; cs = 1'b0; addr = '0; wr_data = '0;
    rd_stb = 1'b0; wr_stb = 1'b0; burst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rd_data in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    m_sum = 8'h00;
    read_sum("R1 checksum after reset");

    // R2/R3: sweep every address with single reads
    for (int a = 0; a < 256; a++) begin
      beat(1'b0, 1'b1, 1'b1, 8'(a), 8'h00, 1'b0);
      chk(a == 0 ? "R3 single read of offset 0" : "R2 single read pattern",
          rd_data, pat(8'(a), m_sum));
    end

    // R4: single writes load, not add
    beat(1'b1, 1'b0, 1'b1, 8'h01, 8'h55, 1'b0); m_sum = 8'h55;
    read_sum("R4 single write 0x55");
    beat(1'b1, 1'b0, 1'b1, 8'h07, 8'h10, 1'b0); m_sum = 8'h10;
    read_sum("R4 second single write loads");

    // R5: one-hot burst write from 0
    cs_gap();
    for (int i = 0; i < 8; i++) beat(1'b1, 1'b0, 1'b1, 8'h00, 8'(1 << i), 1'b1);
    m_sum = 8'hFF;
    read_sum("R5 one-hot burst sum");

    // R6: burst reads from 16 start addresses, addr bus scrambled after beat 0
    for (int s = 0; s < 16; s++) begin
      logic [7:0] st;
      st = (s < 8) ? 8'(s) : 8'(8'hF8 + s - 8);
      cs_gap();
      for (int n = 0; n < 8; n++) begin
        beat(1'b0, 1'b1, 1'b1, (n == 0) ? st : 8'(8'hA5 + n), 8'h00, 1'b1);
        chk("R6 burst read beat", rd_data, pat(8'(st + n), m_sum));
      end
    end

    // R5: burst write lengths 1..8, arithmetic sum
    for (int len = 1; len <= 8; len++) begin
      logic [7:0] acc;
      acc = 8'h00;
      cs_gap();
      for (int i = 0; i < len; i++) begin
        logic [7:0] d;
        d = 8'(len * 37 + i * 91 + 200);
        acc = acc + d;
        beat(1'b1, 1'b0, 1'b1, 8'h30, d, 1'b1);
      end
      m_sum = acc;
      read_sum("R5 burst write sum by length");
    end

    // R7: ninth write and read strobes ignored
    cs_gap();
    for (int i = 0; i < 8; i++) beat(1'b1, 1'b0, 1'b1, 8'h00, 8'h03, 1'b1);
    m_sum = 8'h18;
    beat(1'b1, 1'b0, 1'b1, 8'h00, 8'h44, 1'b1);
    beat(1'b1, 1'b0, 1'b1, 8'h00, 8'h66, 1'b0);
    read_sum("R7 writes after eighth beat ignored");
    cs_gap();
    for (int i = 0; i < 8; i++) beat(1'b0, 1'b1, 1'b1, 8'h01, 8'h00, 1'b1);
    chk("R7 eighth read beat", rd_data, 8'h00);
    beat(1'b0, 1'b1, 1'b1, 8'h03, 8'h00, 1'b0);
    chk("R7 read after eighth beat ignored", rd_data, 8'h00);

    // R8: cs drop restarts the burst; strobes with cs low ignored
    cs_gap();
    beat(1'b1, 1'b0, 1'b1, 8'h00, 8'h01, 1'b1);
    beat(1'b1, 1'b0, 1'b1, 8'h00, 8'h02, 1'b1);
    beat(1'b1, 1'b0, 1'b1, 8'h00, 8'h03, 1'b1);
    cs_gap();
    beat(1'b1, 1'b0, 1'b1, 8'h00, 8'h05, 1'b1);
    beat(1'b1, 1'b0, 1'b1, 8'h00, 8'h05, 1'b1);
    m_sum = 8'h0A;
    read_sum("R8 burst restarts after cs drop");
    beat(1'b1, 1'b0, 1'b0, 8'h00, 8'h77, 1'b0);
    read_sum("R8 write with cs low ignored");
    beat(1'b0, 1'b1, 1'b1, 8'h06, 8'h00, 1'b0);
    beat(1'b0, 1'b1, 1'b0, 8'h02, 8'h00, 1'b0);
    chk("R8 read with cs low ignored", rd_data, 8'h06);

    // R9: both strobes: write taken, read not
    beat(1'b1, 1'b1, 1'b1, 8'h05, 8'h3C, 1'b0);
    m_sum = 8'h3C;
    chk("R9 rd_data held on combined strobe", rd_data, 8'h06);
    read_sum("R9 combined strobe wrote");

    // R1: reset mid-operation
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rd_data cleared by reset", rd_data, 8'h00);
    rst_n = 1'b1; m_sum = 8'h00;
    read_sum("R1 checksum cleared by reset");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule